// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block turns one prefixed vector instruction into a stream of per-element register-file write requests. A start pulse captures the loop length, the sub-vector length, the destination element-width code, the destination register fields and the predication setup. It also captures snapshots of the three integer predicate registers and of the condition-field flags. From the next cycle on, the block issues one element slot per clock and then raises a one-cycle completion pulse.

Each slot names a 64-bit register, a byte-lane offset and an 8-bit byte write-enable vector. Elements pack from the least significant byte upward and spill into the next register once the current one is full. The element's predicate bit is repeated over all bytes the element covers. A masked-off element still consumes its slot, with every enable low, so the lanes of later elements never shift. The arithmetic that produces the data and the register storage itself live outside this block.

Top module: `vec_elem_seq`

## Requirements
- R1: The width code `elw` selects the element size: 00 gives 8 bytes, 01 gives 4 bytes, 10 gives 2 bytes and 11 gives 1 byte.
- R2: For a vector destination, slot k covers byte offset k*size counted from byte 0 of the base register. The slot's `wr_reg` is the base register plus that offset divided by 8, taken modulo 128. Its `wr_lane` is the offset modulo 8.
- R3: In an enabled slot, `wr_be` has exactly `size` consecutive bits set, starting at bit `wr_lane`. In a disabled slot, `wr_be` is 0.
- R4: A start with `vl` = 0 produces no slot with `wr_valid` high, and `done` is high in the cycle after the start.
- R5: The `subvl` code 00/01/10/11 gives 1/2/3/4 sub-elements per element, so VL*(subvl+1) slots are issued. Slot k belongs to element floor(k/(subvl+1)), and every sub-element takes that element's predicate.
- R6: When `pmode` is 0, mask code 000 enables every element. Mask code 001 enables only the element whose index equals `r3`.
- R7: When `pmode` is 0, codes 010 and 011 enable element i when bit i of `r3` is 1 or 0 respectively. Codes 100 and 101 do the same with `r10`, and codes 110 and 111 do the same with `r30`.
- R8: When `pmode` is 1, element i reads the four flags `crf[4i+3:4i]`, with LT at bit 3, GT at bit 2, EQ at bit 1 and SO at bit 0. Codes 000..111 select LT set, LT clear, GT set, GT clear, EQ set, EQ clear, SO set and SO clear.
- R9: When `xtag[2]` is 0, the base register is {xtag[1:0], ra} and the destination is scalar. When `xtag[2]` is 1, the base register is {ra, xtag[1:0]} and the destination is a vector.
- R10: A scalar destination uses the base register and lane 0 for every slot.
- R11: A masked-off element keeps its slot: `wr_valid` is high with `wr_be` all zero, and later slots keep their positions.
- R12: While `rst_n` is low at a clock edge, the sequence is cleared. After reset, `wr_valid` and `done` are low and the next start begins again at element 0. A start that arrives while slots are still being issued is ignored.
- R13: The first slot appears in the cycle after the start and one slot follows per cycle. `done` is high for exactly one cycle, in the cycle after the last slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| vl | input | 7 | Element count, 0..MAX_VL |
| subvl | input | 2 | Sub-elements per element minus one |
| elw | input | 2 | Destination element-width code |
| ra | input | 5 | Base register field |
| xtag | input | 3 | Extra tag: bit 2 vector flag, bits 1:0 extension |
| pmode | input | 1 | 0 integer predication, 1 condition-field predication |
| pcode | input | 3 | Mask code |
| r3 | input | 64 | Integer predicate source snapshot |
| r10 | input | 64 | Integer predicate source snapshot |
| r30 | input | 64 | Integer predicate source snapshot |
| crf | input | 256 | Condition-field flags, four per element |
| wr_valid | output | 1 | Element slot valid |
| wr_reg | output | 7 | Target register index |
| wr_be | output | 8 | Byte write enables |
| wr_lane | output | 3 | Byte lane offset of the element |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a start pulse that lands in the middle of a running sequence with a different loop length. Only a scoreboard that holds the exact slot list of the first sequence can show that the second pulse left no trace. The stimulus pulses start two cycles into a long run and then requires both the slot stream and the completion cycle to match the first sequence alone. Register wrap-around is reached by giving a vector base of 127 with narrow elements, so slots spill past the top index. A reset is pulled in the middle of a run, and the fresh sequence that follows must begin at element 0.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int XLEN   = 64;
    localparam int BYTES  = XLEN / 8;
    localparam int LANE_W = $clog2(BYTES);
    localparam int RA_W   = 5;
    localparam int TAG_W  = 3;
    localparam int REG_W  = RA_W + TAG_W - 1;

    // bytes covered by one element for a width code
    function automatic logic [LANE_W:0] elem_bytes(input logic [1:0] code);
        return (LANE_W+1)'(BYTES) >> code;
    endfunction

endpackage

// File: rtl/vseq_regdec.sv
module vseq_regdec
    import vseq_pkg::*;
(
    input  logic [RA_W-1:0]  ra,
    input  logic [TAG_W-1:0] xtag,
    output logic [REG_W-1:0] base,
    output logic             is_vec
);

    always_comb begin
        is_vec = xtag[TAG_W-1];
        if (is_vec) begin
            base = {ra, xtag[TAG_W-2:0]};
        end else begin
            base = {xtag[TAG_W-2:0], ra};
        end
    end

endmodule

// File: rtl/vseq_pred.sv
module vseq_pred
    import vseq_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic              pmode,
    input  logic [2:0]        pcode,
    input  logic [VL_W-1:0]   elem,
    input  logic [XLEN-1:0]   r3,
    input  logic [XLEN-1:0]   r10,
    input  logic [XLEN-1:0]   r30,
    input  logic [4*MAX_VL-1:0] crf,
    output logic              pred
);

    localparam int EW = $clog2(MAX_VL);

    logic [EW-1:0] idx;
    logic [3:0]    flags;
    logic          raw;

    always_comb begin
        idx   = elem[EW-1:0];
        flags = crf[int'(idx)*4 +: 4];
        raw   = 1'b0;
        if (!pmode) begin
            unique case (pcode)
                3'b000: pred = 1'b1;
                3'b001: pred = (r3 == XLEN'(elem));
                3'b010: pred = r3[idx];
                3'b011: pred = ~r3[idx];
                3'b100: pred = r10[idx];
                3'b101: pred = ~r10[idx];
                3'b110: pred = r30[idx];
                default: pred = ~r30[idx];
            endcase
        end else begin
            unique case (pcode[2:1])
                2'd0: raw = flags[3];
                2'd1: raw = flags[2];
                2'd2: raw = flags[1];
                default: raw = flags[0];
            endcase
            pred = raw ^ pcode[0];
        end
    end

endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
    import vseq_pkg::*;
(
    input  logic [1:0]        elw,
    input  logic [LANE_W-1:0] lane,
    input  logic              pred,
    output logic [BYTES-1:0]  be
);

    logic [BYTES-1:0] span;

    always_comb begin
        span = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (b < int'(elem_bytes(elw))) span[b] = pred;
        end
        be = span << lane;
    end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int CRF_W  = 4 * MAX_VL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic [1:0]        subvl,
    input  logic [1:0]        elw,
    input  logic [RA_W-1:0]   ra,
    input  logic [TAG_W-1:0]  xtag,
    input  logic              pmode,
    input  logic [2:0]        pcode,
    input  logic [XLEN-1:0]   r3,
    input  logic [XLEN-1:0]   r10,
    input  logic [XLEN-1:0]   r30,
    input  logic [CRF_W-1:0]  crf,
    output logic              wr_valid,
    output logic [REG_W-1:0]  wr_reg,
    output logic [BYTES-1:0]  wr_be,
    output logic [LANE_W-1:0] wr_lane,
    output logic              done
);

    typedef struct packed {
        logic [VL_W-1:0]  vl;
        logic [1:0]       subvl;
        logic [1:0]       elw;
        logic             vec;
        logic             pmode;
        logic [2:0]       pcode;
        logic [XLEN-1:0]  r3;
        logic [XLEN-1:0]  r10;
        logic [XLEN-1:0]  r30;
        logic [CRF_W-1:0] crf;
    } cfg_t;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [VL_W-1:0]   elem;
        logic [1:0]        sub;
        logic [REG_W-1:0]  rnum;
        logic [LANE_W-1:0] lane;
        cfg_t              cfg;
    } seq_t;

    seq_t s_d, s_q;

    logic [REG_W-1:0]  base_in;
    logic              vec_in;
    logic              pred_bit;
    logic              last_sub;
    logic              last_slot;
    logic [LANE_W:0]   lane_sum;
    logic [LANE_W:0]   wbytes_q;

    vseq_regdec u_dec (
        .ra     (ra),
        .xtag   (xtag),
        .base   (base_in),
        .is_vec (vec_in)
    );

    vseq_pred #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_pred (
        .pmode (s_q.cfg.pmode),
        .pcode (s_q.cfg.pcode),
        .elem  (s_q.elem),
        .r3    (s_q.cfg.r3),
        .r10   (s_q.cfg.r10),
        .r30   (s_q.cfg.r30),
        .crf   (s_q.cfg.crf),
        .pred  (pred_bit)
    );

    vseq_lane u_lane (
        .elw  (s_q.cfg.elw),
        .lane (s_q.lane),
        .pred (pred_bit & s_q.busy),
        .be   (wr_be)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        wbytes_q  = elem_bytes(s_q.cfg.elw);
        last_sub  = (s_q.sub == s_q.cfg.subvl);
        last_slot = last_sub && ((s_q.elem + VL_W'(1)) == s_q.cfg.vl);
        lane_sum  = {1'b0, s_q.lane} + wbytes_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.cfg.vl    = vl;
                s_d.cfg.subvl = subvl;
                s_d.cfg.elw   = elw;
                s_d.cfg.vec   = vec_in;
                s_d.cfg.pmode = pmode;
                s_d.cfg.pcode = pcode;
                s_d.cfg.r3    = r3;
                s_d.cfg.r10   = r10;
                s_d.cfg.r30   = r30;
                s_d.cfg.crf   = crf;
                s_d.elem      = '0;
                s_d.sub       = '0;
                s_d.rnum      = base_in;
                s_d.lane      = '0;
                if (vl == '0) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                end
            end
        end else begin
            if (last_slot) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
            if (last_sub) begin
                s_d.sub  = '0;
                s_d.elem = s_q.elem + VL_W'(1);
            end else begin
                s_d.sub  = s_q.sub + 2'd1;
            end
            if (s_q.cfg.vec) begin
                s_d.lane = lane_sum[LANE_W-1:0];
                s_d.rnum = s_q.rnum + REG_W'(lane_sum[LANE_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_valid = s_q.busy;
    assign wr_reg   = s_q.rnum;
    assign wr_lane  = s_q.lane;
    assign done     = s_q.done;

    // R3: enables either all clear or exactly one element wide
    a_r3_be_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($countones(wr_be) == 0 ||
                      $countones(wr_be) == int'(wbytes_q)));

    // R2: each element starts on a lane aligned to its own size
    a_r2_lane_align: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_lane & LANE_W'(wbytes_q - 1'b1)) == '0));

    // R4: empty loop completes at once without writes
    a_r4_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wr_valid && vl == '0) |=> (done && !wr_valid));

    // R13: completion is a single-cycle pulse
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: a running sequence never restarts at element zero
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !(wr_valid && s_q.elem == '0 && s_q.sub == '0));

    // R10: a scalar destination holds its register across slots
    a_r10_scalar_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !s_q.cfg.vec && $past(wr_valid)) |-> ($stable(wr_reg) && wr_lane == '0));

endmodule

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [6:0]   vl_i = '0;
    logic [1:0]   subvl_i = '0;
    logic [1:0]   elw_i = '0;
    logic [4:0]   ra_i = '0;
    logic [2:0]   xtag_i = '0;
    logic         pmode_i = 1'b0;
    logic [2:0]   pcode_i = '0;
    logic [63:0]  r3_i = '0, r10_i = '0, r30_i = '0;
    logic [255:0] crf_i = '0;
    logic         wr_valid;
    logic [6:0]   wr_reg;
    logic [7:0]   wr_be;
    logic [2:0]   wr_lane;
    logic         done;

    typedef struct {
        logic [6:0] rnum;
        logic [7:0] be;
        logic [2:0] lane;
        string      req;
    } item_t;

    item_t exp_q[$];
    int    errors = 0;
    int    checks = 0;

    always #4 clk = ~clk;

    vec_elem_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_i), .subvl(subvl_i),
        .elw(elw_i), .ra(ra_i), .xtag(xtag_i), .pmode(pmode_i), .pcode(pcode_i),
        .r3(r3_i), .r10(r10_i), .r30(r30_i), .crf(crf_i),
        .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_be(wr_be), .wr_lane(wr_lane),
        .done(done)
    );

    task automatic check(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // monitor: compare every issued slot against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected slot reg", longint'(wr_reg), -1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(wr_reg == it.rnum, {it.req, " reg"}, longint'(wr_reg), longint'(it.rnum));
                check(wr_lane == it.lane, {it.req, " lane"}, longint'(wr_lane), longint'(it.lane));
                check(wr_be == it.be, {it.req, " be"}, longint'(wr_be), longint'(it.be));
            end
        end
    end

    function automatic bit exp_pred(input int e, input bit pm, input logic [2:0] pc);
        logic [3:0] f;
        bit t;
        if (!pm) begin
            case (pc)
                3'd0: return 1'b1;
                3'd1: return r3_i == 64'(e);
                3'd2: return r3_i[e];
                3'd3: return !r3_i[e];
                3'd4: return r10_i[e];
                3'd5: return !r10_i[e];
                3'd6: return r30_i[e];
                default: return !r30_i[e];
            endcase
        end
        f = crf_i[4*e +: 4];
        case (pc[2:1])
            2'd0: t = f[3];
            2'd1: t = f[2];
            2'd2: t = f[1];
            default: t = f[0];
        endcase
        return t ^ pc[0];
    endfunction

    task automatic push_expected(input string req, input int vl, input int sv, input int ew,
                                 input logic [4:0] ra, input logic [2:0] xt,
                                 input bit pm, input logic [2:0] pc);
        int wb = 8 >> ew;
        logic [6:0] base = xt[2] ? {ra, xt[1:0]} : {xt[1:0], ra};
        for (int k = 0; k < vl * (sv + 1); k++) begin
            item_t it;
            int off = k * wb;
            bit p = exp_pred(k / (sv + 1), pm, pc);
            if (xt[2]) begin
                it.rnum = 7'((int'(base) + off / 8) % 128);
                it.lane = 3'(off % 8);
            end else begin
                it.rnum = base;
                it.lane = 3'd0;
            end
            it.be  = p ? 8'(((1 << wb) - 1) << int'(it.lane)) : 8'h00;
            it.req = req;
            exp_q.push_back(it);
        end
    endtask

    task automatic run_seq(input string req, input int vl, input int sv, input int ew,
                           input logic [4:0] ra, input logic [2:0] xt,
                           input bit pm, input logic [2:0] pc, input bit poke);
        int n = 1;
        push_expected(req, vl, sv, ew, ra, xt, pm, pc);
        vl_i = 7'(vl); subvl_i = 2'(sv); elw_i = 2'(ew);
        ra_i = ra; xtag_i = xt; pmode_i = pm; pcode_i = pc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk); n++;
            vl_i = 7'd1; ra_i = 5'd3; start = 1'b1;
            @(negedge clk); n++;
            start = 1'b0;
        end
        while (!done && n < 400) begin
            @(negedge clk); n++;
        end
        check(done == 1'b1 && n == vl * (sv + 1) + 1,
              {req, " R13 done cycle"}, longint'(n), longint'(vl * (sv + 1) + 1));
        check(exp_q.size() == 0, {req, " R5 slot count left"}, longint'(exp_q.size()), 0);
        exp_q.delete();
        @(negedge clk);
        check(done == 1'b0, {req, " R13 done width"}, longint'(done), 0);
    endtask

    task automatic randomize_preds();
        r3_i  = {$urandom, $urandom};
        r10_i = {$urandom, $urandom};
        r30_i = {$urandom, $urandom};
        for (int w = 0; w < 8; w++) crf_i[32*w +: 32] = $urandom;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(wr_valid == 1'b0, "R12 reset valid", longint'(wr_valid), 0);
        check(done == 1'b0, "R12 reset done", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        randomize_preds();

        run_seq("R1 R2 full width", 4, 0, 0, 5'd4, 3'b100, 0, 3'd0, 0);
        run_seq("R1 R2 R7 bytes r3 set", 10, 0, 3, 5'd2, 3'b101, 0, 3'd2, 0);
        run_seq("R5 R7 R11 half r3 clear", 5, 2, 2, 5'd6, 3'b110, 0, 3'd3, 0);
        r3_i = 64'd2;
        run_seq("R6 single element", 6, 1, 1, 5'd1, 3'b100, 0, 3'd1, 0);
        r3_i = 64'd200;
        run_seq("R6 index out of range", 3, 0, 0, 5'd1, 3'b100, 0, 3'd1, 0);
        randomize_preds();
        run_seq("R7 r10 set", 12, 0, 2, 5'd9, 3'b100, 0, 3'd4, 0);
        run_seq("R7 r10 clear", 12, 0, 2, 5'd9, 3'b100, 0, 3'd5, 0);
        run_seq("R7 r30 set", 9, 1, 3, 5'd9, 3'b111, 0, 3'd6, 0);
        run_seq("R7 r30 clear", 9, 0, 1, 5'd9, 3'b111, 0, 3'd7, 0);
        for (int c = 0; c < 8; c++) begin
            run_seq("R8 cond field", 16, 0, 3, 5'd20, 3'b101, 1, 3'(c), 0);
        end
        run_seq("R9 R10 scalar word", 6, 0, 1, 5'd7, 3'b011, 0, 3'd2, 0);
        run_seq("R9 R10 scalar subvl", 3, 3, 3, 5'd31, 3'b010, 1, 3'd4, 0);
        run_seq("R4 empty loop", 0, 0, 0, 5'd1, 3'b100, 0, 3'd0, 0);
        run_seq("R4 empty loop subvl", 0, 3, 3, 5'd1, 3'b100, 1, 3'd1, 0);
        run_seq("R2 register wrap", 20, 0, 2, 5'd31, 3'b111, 0, 3'd0, 0);
        run_seq("R12 start while busy", 8, 0, 1, 5'd2, 3'b100, 0, 3'd3, 1);
        run_seq("R5 R11 max loop", 64, 3, 3, 5'd0, 3'b100, 0, 3'd2, 0);

        // R12: reset in the middle of a run, then a fresh sequence
        vl_i = 7'd30; subvl_i = 2'd0; elw_i = 2'd0; xtag_i = 3'b100; ra_i = 5'd8;
        pcode_i = 3'd0; pmode_i = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_q.delete();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(wr_valid == 1'b0, "R12 mid-run reset valid", longint'(wr_valid), 0);
        check(done == 1'b0, "R12 mid-run reset done", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq("R12 after reset", 3, 0, 0, 5'd12, 3'b100, 0, 3'd0, 0);

        for (int t = 0; t < 40; t++) begin
            randomize_preds();
            run_seq("R2 R3 mixed", 1 + int'($urandom % 24), int'($urandom % 4),
                    int'($urandom % 4), 5'($urandom), 3'($urandom),
                    1'($urandom), 3'($urandom), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule